// File: doc/BRIEF.md
# Link PDU Packer with Inline Status Octets

This block turns a serial character stream into fixed-capacity protocol data units for a radio link layer. Characters enter on a byte stream with valid/ready flow control. Three control-circuit status bits (SA, SB and X) are watched as plain level inputs. Every change of those bits becomes a status octet. The status octet is written into the unit at the exact point in the character stream where the change was seen, so the characters before it and after it stay in their order around it. Finished units leave on a byte stream with first-octet and last-octet markers and a flag that tells status octets apart from data octets.

A unit is closed in three cases. It closes when it is full. It closes early when the link says it can take another unit and the unit holds at least one octet. It also closes when a status change is waiting and only one slot is left, so the status octet opens the next unit. A link setup or reset pulse drops any partial assembly and any waiting status events. It then sends a one-octet unit that carries the present status.

Back-pressure rules: a character is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is low while a unit is being sent, while a status event is waiting or being detected, while a setup unit is pending, and in a cycle where a unit closes. On the output, an octet is consumed on an edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the output holds the same octet and markers.

Top module: `lnk_pdu_packer`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1, and the tracked status is all OFF (each bit 1).
- R2: Octets leave in the order they were placed. A data octet keeps its value and has `out_stat` = 0.
- R3: While `link_ready` stays low, a unit closes once it holds `PDU_CAP` octets (default 30), and no unit is ever longer than that.
- R4: With at least one octet held, `link_ready` high closes the unit in that cycle. `out_sop` marks the first octet of each unit and `out_eop` marks the last.
- R5: A change in any of {SA,SB,X} places a status octet with `out_stat` = 1 and value {3'b110, SA, SB, X, 2'b00} (bits 7:5 tag, bit 4 SA, bit 3 SB, bit 2 X; 0 = ON, 1 = OFF, X = 1 means flow control active). The octet goes ahead of every character accepted after the change. In the cycle a change is seen, no character is accepted.
- R6: A bit that toggles and then returns on the next cycle produces two status octets in order: first the new value, then the old one.
- R7: A status event that is waiting when the unit holds `PDU_CAP`-1 octets closes the unit at that length, and the status octet becomes the first octet of the next unit.
- R8: A `link_start` pulse discards a partially assembled unit and all waiting status events. It then sends a one-octet unit holding the status octet for the present inputs.
- R9: `in_ready` stays low while a unit is being sent. While `out_valid` is high and `out_ready` is low, the output octet and markers do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Character will be taken this cycle |
| in_data | input | 8 | Character value |
| stat_sa | input | 1 | Status bit SA level (0 = ON) |
| stat_sb | input | 1 | Status bit SB level (0 = ON) |
| stat_x | input | 1 | Status bit X level (1 = flow control active) |
| link_ready | input | 1 | Link can accept another unit |
| link_start | input | 1 | Pulse: link established or reset |
| out_valid | output | 1 | Output octet present |
| out_ready | input | 1 | Sink takes the octet |
| out_data | output | 8 | Output octet |
| out_stat | output | 1 | Octet is a status octet |
| out_sop | output | 1 | First octet of a unit |
| out_eop | output | 1 | Last octet of a unit |

## Verification
Suppose the unit length or read index is wrong. Then `out_sop` and `out_eop` land on the wrong beat of the first unit sent after the fault, and the unit length checked against `PDU_CAP` or the early-close point goes wrong at once. Suppose the last-seen status register or the event queue is wrong. Then a status octet is missing, extra, or carries the wrong value, and the next beat compared against the stream model in the bench shows it. A closure rule that fires at the wrong time shows as a wrong unit length in the directed cases, within one unit's drain time.

// File: rtl/lnk_pdu_pkg.sv
`timescale 1ns/1ps
package lnk_pdu_pkg;
  localparam int OCT_W = 8;
  localparam int STAT_W = 3;
  localparam logic [2:0] STAT_TAG = 3'b110;
  localparam logic [STAT_W-1:0] STAT_ALL_OFF = 3'b111;

  typedef enum logic {ST_FILL, ST_SEND} frm_state_e;

  typedef struct packed {
    logic             is_stat;
    logic [OCT_W-1:0] oct;
  } slot_t;

  // status octet: tag in 7:5, SA bit 4, SB bit 3, X bit 2
  function automatic logic [OCT_W-1:0] stat_octet(input logic [STAT_W-1:0] s);
    return {STAT_TAG, s, 2'b00};
  endfunction
endpackage

// File: rtl/lnk_stat_fifo.sv
`timescale 1ns/1ps
module lnk_stat_fifo #(
  parameter int WIDTH = 3,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             full, do_push, do_pop;

  assign full    = (cnt == CNT_W'(DEPTH));
  assign empty   = (cnt == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clear) mem[wr_ptr] <= din;
  end

  // R6: every status event must fit; a dropped one would break the ordered pair
  stq_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !clear) |-> (!full || pop));
endmodule

// File: rtl/lnk_stat_track.sv
`timescale 1ns/1ps
module lnk_stat_track
  import lnk_pdu_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat_in,
  input  logic              hold,
  input  logic              pop,
  output logic              ev_valid,
  output logic [STAT_W-1:0] ev_stat,
  output logic              chg,
  output logic [STAT_W-1:0] cur_stat
);
  logic [STAT_W-1:0] stat_last;
  logic              q_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_last <= STAT_ALL_OFF;
    else        stat_last <= stat_in;
  end

  assign chg      = (stat_in != stat_last);
  assign cur_stat = stat_in;
  assign ev_valid = !q_empty;

  lnk_stat_fifo #(.WIDTH(STAT_W), .DEPTH(DEPTH)) ev_q_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (hold),
    .push  (chg && !hold),
    .din   (stat_in),
    .pop   (pop),
    .dout  (ev_stat),
    .empty (q_empty)
  );

  // R5
  chg_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg && !hold) |=> ev_valid);
endmodule

// File: rtl/lnk_frame_core.sv
`timescale 1ns/1ps
module lnk_frame_core
  import lnk_pdu_pkg::*;
#(
  parameter int CAP = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OCT_W-1:0]  in_data,
  output logic              in_ready,
  input  logic              ev_valid,
  input  logic [STAT_W-1:0] ev_stat,
  output logic              ev_pop,
  input  logic [STAT_W-1:0] cur_stat,
  input  logic              chg,
  output logic              init_wr,
  input  logic              link_ready,
  input  logic              link_start,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [OCT_W-1:0]  out_data,
  output logic              out_stat,
  output logic              out_sop,
  output logic              out_eop
);
  localparam int LEN_W = $clog2(CAP + 1);
  localparam int IDX_W = (CAP > 1) ? $clog2(CAP) : 1;

  frm_state_e       state;
  logic [LEN_W-1:0] len;
  logic [IDX_W-1:0] rd;
  logic             init_pend;
  slot_t            mem [CAP];

  logic fill, is_full, early, last_slot, close_stat, blocked;
  logic char_wr, go_send, last_beat, wr_en;
  logic [IDX_W-1:0] wr_idx;
  slot_t            wr_slot, rd_slot;

  always_comb begin
    fill       = (state == ST_FILL);
    is_full    = (len == LEN_W'(CAP));
    early      = link_ready && (len != '0);
    last_slot  = (len == LEN_W'(CAP - 1));
    close_stat = ev_valid && last_slot;
    blocked    = init_pend || is_full || early;
    init_wr    = fill && init_pend;
    ev_pop     = fill && !blocked && ev_valid && !last_slot;
    in_ready   = fill && !blocked && !ev_valid && !chg;
    char_wr    = in_valid && in_ready;
    go_send    = fill && !init_pend && (is_full || early || close_stat);
    wr_en      = init_wr || ev_pop || char_wr;
    wr_idx     = init_wr ? '0 : IDX_W'(len);
    if (init_wr)     wr_slot = '{is_stat: 1'b1, oct: stat_octet(cur_stat)};
    else if (ev_pop) wr_slot = '{is_stat: 1'b1, oct: stat_octet(ev_stat)};
    else             wr_slot = '{is_stat: 1'b0, oct: in_data};
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_slot;
  end

  assign rd_slot   = mem[rd];
  assign last_beat = ((LEN_W'(rd) + LEN_W'(1)) == len);
  assign out_valid = (state == ST_SEND);
  assign out_data  = rd_slot.oct;
  assign out_stat  = rd_slot.is_stat;
  assign out_sop   = (rd == '0);
  assign out_eop   = last_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_FILL;
      len       <= '0;
      rd        <= '0;
      init_pend <= 1'b0;
    end else begin
      if (init_wr)    init_pend <= 1'b0;
      if (link_start) init_pend <= 1'b1;
      case (state)
        ST_FILL: begin
          if (init_wr) begin
            len   <= LEN_W'(1);
            rd    <= '0;
            state <= ST_SEND;
          end else if (go_send) begin
            rd    <= '0;
            state <= ST_SEND;
          end else if (ev_pop || char_wr) begin
            len <= len + LEN_W'(1);
          end
        end
        ST_SEND: begin
          if (out_ready) begin
            if (last_beat) begin
              state <= ST_FILL;
              len   <= '0;
              rd    <= '0;
            end else begin
              rd <= rd + IDX_W'(1);
            end
          end
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_stat) && $stable(out_eop)));
  // R9
  no_take_while_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  // R3
  len_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len <= LEN_W'(CAP));
  // R5
  chg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> !in_ready);
  // R8
  init_pdu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_wr |=> (out_valid && out_sop && out_eop && out_stat));
endmodule

// File: rtl/lnk_pdu_packer.sv
`timescale 1ns/1ps
module lnk_pdu_packer
  import lnk_pdu_pkg::*;
#(
  parameter int PDU_CAP   = 30,
  parameter int STQ_DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       stat_sa,
  input  logic       stat_sb,
  input  logic       stat_x,
  input  logic       link_ready,
  input  logic       link_start,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_stat,
  output logic       out_sop,
  output logic       out_eop
);
  logic              ev_valid, ev_pop, chg, init_wr;
  logic [STAT_W-1:0] ev_stat, cur_stat;

  lnk_stat_track #(.DEPTH(STQ_DEPTH)) track_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .stat_in  ({stat_sa, stat_sb, stat_x}),
    .hold     (init_wr),
    .pop      (ev_pop),
    .ev_valid (ev_valid),
    .ev_stat  (ev_stat),
    .chg      (chg),
    .cur_stat (cur_stat)
  );

  lnk_frame_core #(.CAP(PDU_CAP)) core_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_data    (in_data),
    .in_ready   (in_ready),
    .ev_valid   (ev_valid),
    .ev_stat    (ev_stat),
    .ev_pop     (ev_pop),
    .cur_stat   (cur_stat),
    .chg        (chg),
    .init_wr    (init_wr),
    .link_ready (link_ready),
    .link_start (link_start),
    .out_valid  (out_valid),
    .out_ready  (out_ready),
    .out_data   (out_data),
    .out_stat   (out_stat),
    .out_sop    (out_sop),
    .out_eop    (out_eop)
  );
endmodule

// File: tb/lnk_pdu_packer_tb_top.sv
`timescale 1ns/1ps
module lnk_pdu_packer_tb_top;
  localparam int CAP = 30;

  logic clk, rst_n, in_valid, link_ready, link_start, out_ready;
  logic sa, sb, x;
  logic [7:0] in_data;
  logic in_ready, out_valid, out_stat, out_sop, out_eop;
  logic [7:0] out_data;

  int checks = 0, fails = 0;
  logic [8:0] exp_q[$];
  int cur_len = 0, last_len = 0, pdu_cnt = 0, acc_cnt = 0;
  logic cur_first_stat = 0, last_first_stat = 0;
  logic [8:0] last_oct = '0;
  logic [2:0] prev_stat = 3'b111;

  lnk_pdu_packer #(.PDU_CAP(CAP), .STQ_DEPTH(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .stat_sa(sa), .stat_sb(sb), .stat_x(x),
    .link_ready(link_ready), .link_start(link_start), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_stat(out_stat),
    .out_sop(out_sop), .out_eop(out_eop));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] ref_oct(input logic [2:0] s);
    return 8'hC0 | {3'b000, s, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic observe();
    logic [2:0] s;
    logic [8:0] e;
    s = {sa, sb, x};
    if (s != prev_stat) begin
      exp_q.push_back({1'b1, ref_oct(s)});
      chk(in_ready == 1'b0, "R5 no char in change cycle", in_ready, 0);
      prev_stat = s;
    end
    if (in_valid && in_ready) begin
      exp_q.push_back({1'b0, in_data});
      acc_cnt++;
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected octet", {out_stat, out_data}, 0);
      end else begin
        e = exp_q.pop_front();
        chk({out_stat, out_data} == e, "R2/R5/R6 octet order and value",
            {out_stat, out_data}, e);
      end
      chk(out_sop == (cur_len == 0), "R4 sop on first octet", out_sop, cur_len == 0);
      if (cur_len == 0) cur_first_stat = out_stat;
      cur_len++;
      if (out_eop) begin
        chk(cur_len <= CAP, "R3 unit within capacity", cur_len, CAP);
        last_len = cur_len;
        last_first_stat = cur_first_stat;
        last_oct = {out_stat, out_data};
        pdu_cnt++;
        cur_len = 0;
      end
    end
  endtask

  task automatic step();
    #1;
    observe();
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) step();
  endtask

  task automatic send_chars(input int n);
    int tgt;
    tgt = acc_cnt + n;
    in_valid = 1'b1;
    in_data = 8'($urandom);
    while (acc_cnt < tgt) begin
      int b = acc_cnt;
      step();
      if (acc_cnt != b) in_data = 8'($urandom);
    end
    in_valid = 1'b0;
  endtask

  task automatic pulse_link();
    link_ready = 1'b1;
    step();
    link_ready = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #4000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int p0, gap;
    logic [7:0] held;
    logic acc_last;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; link_ready = 1'b0;
    link_start = 1'b0; out_ready = 1'b1; {sa, sb, x} = 3'b111;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", in_ready, 1);
    @(negedge clk);

    // R3 full unit
    p0 = pdu_cnt;
    send_chars(CAP);
    idle(40);
    chk(pdu_cnt == p0 + 1, "R3 one unit when full", pdu_cnt - p0, 1);
    chk(last_len == CAP, "R3 full unit length", last_len, CAP);

    // R4 early close
    send_chars(3);
    pulse_link();
    idle(10);
    chk(last_len == 3, "R4 early close length", last_len, 3);

    // R7 status with one slot left
    send_chars(CAP - 1);
    sa = ~sa;
    idle(45);
    chk(last_len == CAP - 1, "R7 closed at cap-1", last_len, CAP - 1);
    chk(last_first_stat == 1'b0, "R7 prior unit all data", last_first_stat, 0);
    pulse_link();
    idle(5);
    chk(last_len == 1, "R7 status opens next unit", last_len, 1);
    chk(last_first_stat == 1'b1, "R7 first octet is status", last_first_stat, 1);

    // R6 toggle and return
    x = ~x;
    step();
    x = ~x;
    step();
    idle(4);
    pulse_link();
    idle(5);
    chk(last_len == 2, "R6 both edges emitted", last_len, 2);

    // R5 status between characters, change in same cycle as offer
    send_chars(1);
    sb = ~sb;
    send_chars(1);
    pulse_link();
    idle(5);
    chk(last_len == 3, "R5 status between chars", last_len, 3);

    // R8 setup unit with present status
    {sa, sb, x} = 3'b010;
    idle(3);
    pulse_link();
    idle(5);
    link_start = 1'b1;
    exp_q.push_back({1'b1, ref_oct(3'b010)});
    step();
    link_start = 1'b0;
    idle(5);
    chk(last_len == 1, "R8 setup unit length", last_len, 1);
    chk(last_oct == 9'h1C8, "R8 setup octet value", last_oct, 9'h1C8);

    // R8 partial assembly discarded
    send_chars(2);
    link_start = 1'b1;
    exp_q.delete();
    exp_q.push_back({1'b1, ref_oct({sa, sb, x})});
    step();
    link_start = 1'b0;
    idle(5);
    chk(last_len == 1, "R8 partial discarded", last_len, 1);
    chk(last_oct == {1'b1, ref_oct({sa, sb, x})}, "R8 discard octet", last_oct,
        {1'b1, ref_oct({sa, sb, x})});

    // R9 back-pressure
    out_ready = 1'b0;
    send_chars(CAP);
    in_valid = 1'b1;
    in_data = 8'h5A;
    step();
    held = out_data;
    repeat (5) begin
      step();
      chk(in_ready == 1'b0, "R9 in_ready low while sending", in_ready, 0);
      chk(out_valid && out_sop, "R9 output held", {out_valid, out_sop}, 3);
      chk(out_data == held, "R9 output stable", out_data, held);
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    idle(40);

    // random phase
    gap = 0;
    acc_last = 1'b1;
    repeat (6000) begin
      if (!in_valid || acc_last) begin
        in_valid = (($urandom % 10) < 7);
        in_data = 8'($urandom);
      end
      out_ready = (($urandom % 4) != 0);
      link_ready = (($urandom % 20) == 0);
      gap++;
      if (gap > 60 && ($urandom % 30) == 0) begin
        case ($urandom % 3)
          0: sa = ~sa;
          1: sb = ~sb;
          default: x = ~x;
        endcase
        gap = 0;
      end
      begin
        int b = acc_cnt;
        step();
        acc_last = (acc_cnt != b);
      end
    end
    in_valid = 1'b0;
    out_ready = 1'b1;
    link_ready = 1'b1;
    idle(100);
    chk(exp_q.size() == 0, "R2 all octets delivered", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule